// File: doc/BRIEF.md
# Physical Memory Protection Range Checker

This block guards physical memory with a small table of protection entries. Each entry pairs an address register with a configuration byte that selects how the entry's region is formed and which kinds of access it permits. For every address presented on the check port, the block works out which entries cover it, picks the lowest-numbered covering entry as the deciding one, and reports whether the access is allowed or faults.

Region shapes are top-of-range (the entry's lower bound is the previous entry's address register), a naturally aligned 4-byte word, and a naturally aligned power-of-two block encoded by trailing ones in the address register. Entries can be locked. A locked entry freezes its own settings until reset and also binds machine-mode accesses. The register write port is synchronous. The check path is purely combinational, so a new address gives a result in the same cycle.

Top module: `pmp_guard`

## Requirements
- R1: An address register holds a physical address shifted right by two, and every comparison uses that register with two zero bits appended below it.
- R2: In top-of-range mode (mode field 01), entry i covers PA when reg[i-1]*4 <= PA < reg[i]*4. Entry 0 uses zero as its lower bound. If reg[i] <= reg[i-1], the entry covers nothing.
- R3: In 4-byte mode (mode field 10), an entry covers exactly the four bytes from reg*4 up to reg*4+3.
- R4: In aligned-block mode (mode field 11), t trailing ones in the register select a block of 2^(t+3) bytes. The block is aligned to its size and contains reg*4.
- R5: Configuration byte i occupies bits 8i+7:8i of the configuration word, so entry 7 sits in bits 63:56. Within a byte, bit 7 is lock, bits 4:3 are the mode and bits 2, 1 and 0 permit execute, write and read. Mode 00 covers nothing.
- R6: match_o bit i reports whether entry i covers the address. It is computed for every entry whether or not a lower-numbered entry also covers the address.
- R7: win_o is one-hot on the lowest-numbered covering entry, or zero when no entry covers the address.
- R8: chk_acc_i is {execute, write, read}. The winning entry permits the access when every requested bit is also set among its permission bits.
- R9: With chk_priv_i = 11 (machine), an access is allowed when no entry covers it or when the winner is unlocked. When the winner is locked, its permission bits decide.
- R10: With chk_priv_i other than 11, a covered access follows the winner's permission bits. An uncovered access is denied if any entry has a nonzero mode, and allowed otherwise.
- R11: While an entry's lock bit is set, writes to its configuration byte and to its address register are ignored until reset.
- R12: While entry i+1 is locked in top-of-range mode, writes to address register i are ignored.
- R13: fault_o is always the inverse of allow_o.
- R14: Reset clears every address register and configuration byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register write port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_we_i | input | 1 | Write strobe for one address register |
| addr_idx_i | input | $clog2(N_ENT) | Index of the address register to write |
| addr_wd_i | input | PA_W-2 | Address register write data (PA >> 2) |
| cfg_we_i | input | 1 | Write strobe for the packed configuration word |
| cfg_wd_i | input | 8*N_ENT | Packed configuration bytes, entry i in byte i |
| chk_pa_i | input | PA_W | Physical address under check |
| chk_acc_i | input | 3 | Requested access {execute, write, read} |
| chk_priv_i | input | 2 | Privilege mode, 11 = machine |
| match_o | output | N_ENT | Per-entry coverage vector |
| win_o | output | N_ENT | One-hot deciding entry |
| allow_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access faults |

## Verification
The bench sweeps every address of an 8-bit physical space, each access type and both privilege classes. Its table mixes overlapping regions, a disabled entry whose register still bounds the next one, and a locked top-of-range entry. A design that let the winner mask the other entries would clear match bits inside overlaps. An off-by-one in the top bound, or a wrong lower bound for entry 0, would misreport the bytes at each region edge. Wrong trailing-ones sizing would shift aligned blocks, including the one that covers the whole space. The bench also writes to locked state and to the register below a locked top-of-range entry. A design that dropped either protection would then move region edges, and so change the sweep results, until reset cleared the locks.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;
  typedef enum logic [1:0] {
    AM_OFF   = 2'b00,
    AM_TOR   = 2'b01,
    AM_NA4   = 2'b10,
    AM_NAPOT = 2'b11
  } amode_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;
endpackage

// File: rtl/pmp_guard_regs.sv
module pmp_guard_regs
  import pmp_guard_pkg::*;
#(
  parameter int N    = 8,
  parameter int AR_W = 54
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  addr_we_i,
  input  logic [$clog2(N)-1:0]  addr_idx_i,
  input  logic [AR_W-1:0]       addr_wd_i,
  input  logic                  cfg_we_i,
  input  logic [8*N-1:0]        cfg_wd_i,
  output ent_cfg_t              cfg_o  [N],
  output logic [AR_W-1:0]       addr_o [N]
);
  localparam int IW = $clog2(N);

  ent_cfg_t        cfg_q  [N];
  logic [AR_W-1:0] addr_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic guard_nxt;
    logic addr_sel;
    if (i < N - 1) begin : g_nxt
      // locked TOR entry above uses this register as its lower bound
      assign guard_nxt = cfg_q[i+1].lock && (cfg_q[i+1].mode == AM_TOR);
    end else begin : g_last
      assign guard_nxt = 1'b0;
    end
    assign addr_sel = addr_we_i && (addr_idx_i == IW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end else begin
        if (cfg_we_i && !cfg_q[i].lock) cfg_q[i] <= ent_cfg_t'(cfg_wd_i[8*i +: 8]);
        if (addr_sel && !cfg_q[i].lock && !guard_nxt) addr_q[i] <= addr_wd_i;
      end
    end

    assign cfg_o[i]  = cfg_q[i];
    assign addr_o[i] = addr_q[i];
  end
endmodule

// File: rtl/pmp_guard_match.sv
module pmp_guard_match
  import pmp_guard_pkg::*;
#(
  parameter int PA_W = 56,
  parameter int AR_W = PA_W - 2
) (
  input  logic [PA_W-1:0] pa_i,
  input  logic [AR_W-1:0] ar_i,
  input  amode_e          mode_i,
  input  logic            ge_prev_i,
  output logic            ge_o,
  output logic            hit_o
);
  logic [PA_W-1:0] bound;
  logic [AR_W-1:0] pa_w;
  logic [AR_W-1:0] keep;
  logic            lt;

  assign bound = {ar_i, 2'b00};
  assign ge_o  = pa_i >= bound;
  assign lt    = pa_i < bound;
  assign pa_w  = pa_i[PA_W-1:2];
  // trailing ones plus the next bit are don't-care for NAPOT
  assign keep  = ~(ar_i ^ (ar_i + AR_W'(1)));

  always_comb begin
    unique case (mode_i)
      AM_TOR:   hit_o = ge_prev_i && lt;
      AM_NA4:   hit_o = pa_w == ar_i;
      AM_NAPOT: hit_o = (pa_w & keep) == (ar_i & keep);
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_guard_decide.sv
module pmp_guard_decide #(
  parameter int N = 8
) (
  input  logic [N-1:0]      match_i,
  input  logic [N-1:0]      lock_i,
  input  logic [N-1:0]      en_i,
  input  logic [N-1:0][2:0] perm_i,
  input  logic [2:0]        acc_i,
  input  logic [1:0]        priv_i,
  output logic [N-1:0]      win_o,
  output logic              allow_o
);
  logic       seen;
  logic       lk;
  logic [2:0] perm;
  logic       ok;

  always_comb begin
    win_o = '0;
    seen  = 1'b0;
    lk    = 1'b0;
    perm  = 3'b000;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && !seen) begin
        win_o[i] = 1'b1;
        seen     = 1'b1;
        lk       = lock_i[i];
        perm     = perm_i[i];
      end
    end
    ok = (acc_i & ~perm) == 3'b000;
    if (priv_i == 2'b11) allow_o = !seen || !lk || ok;
    else                 allow_o = seen ? ok : !(|en_i);
  end
endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int PA_W  = 56
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     addr_we_i,
  input  logic [$clog2(N_ENT)-1:0] addr_idx_i,
  input  logic [PA_W-3:0]          addr_wd_i,
  input  logic                     cfg_we_i,
  input  logic [8*N_ENT-1:0]       cfg_wd_i,
  input  logic [PA_W-1:0]          chk_pa_i,
  input  logic [2:0]               chk_acc_i,
  input  logic [1:0]               chk_priv_i,
  output logic [N_ENT-1:0]         match_o,
  output logic [N_ENT-1:0]         win_o,
  output logic                     allow_o,
  output logic                     fault_o
);
  localparam int AR_W = PA_W - 2;

  ent_cfg_t              cfg_w  [N_ENT];
  logic [AR_W-1:0]       addr_w [N_ENT];
  logic [N_ENT:0]        ge_c;
  logic [N_ENT-1:0]      lock_v;
  logic [N_ENT-1:0]      en_v;
  logic [N_ENT-1:0][2:0] perm_v;

  pmp_guard_regs #(.N(N_ENT), .AR_W(AR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_we_i  (addr_we_i),
    .addr_idx_i (addr_idx_i),
    .addr_wd_i  (addr_wd_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_wd_i   (cfg_wd_i),
    .cfg_o      (cfg_w),
    .addr_o     (addr_w)
  );

  assign ge_c[0] = 1'b1;  // entry 0 TOR lower bound is zero

  for (genvar i = 0; i < N_ENT; i++) begin : g_chk
    pmp_guard_match #(.PA_W(PA_W), .AR_W(AR_W)) u_match (
      .pa_i      (chk_pa_i),
      .ar_i      (addr_w[i]),
      .mode_i    (cfg_w[i].mode),
      .ge_prev_i (ge_c[i]),
      .ge_o      (ge_c[i+1]),
      .hit_o     (match_o[i])
    );
    assign lock_v[i] = cfg_w[i].lock;
    assign en_v[i]   = cfg_w[i].mode != AM_OFF;
    assign perm_v[i] = {cfg_w[i].x, cfg_w[i].w, cfg_w[i].r};
  end

  pmp_guard_decide #(.N(N_ENT)) u_decide (
    .match_i (match_o),
    .lock_i  (lock_v),
    .en_i    (en_v),
    .perm_i  (perm_v),
    .acc_i   (chk_acc_i),
    .priv_i  (chk_priv_i),
    .win_o   (win_o),
    .allow_o (allow_o)
  );

  assign fault_o = !allow_o;
endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk
  import pmp_guard_pkg::*;
#(
  parameter int N    = 8,
  parameter int AR_W = 54
) (
  input logic            clk_i,
  input logic            rst_ni,
  input ent_cfg_t        cfg_q  [N],
  input logic [AR_W-1:0] addr_q [N],
  input logic [1:0]      chk_priv_i,
  input logic [N-1:0]    match_o,
  input logic [N-1:0]    win_o,
  input logic            allow_o,
  input logic            fault_o
);
  logic any_en;
  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < N; i++) any_en |= (cfg_q[i].mode != AM_OFF);
  end

  assert_win_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o));
  assert_win_in_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_o & ~match_o) == '0);
  assert_win_present_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|match_o) |-> (|win_o));
  assert_fault_inverse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == !allow_o);
  assert_deny_unmatched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_priv_i != 2'b11 && match_o == '0 && any_en) |-> fault_o);

  for (genvar i = 0; i < N; i++) begin : g_lk
    assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i].lock |=> $stable(cfg_q[i]));
    assert_addr_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i].lock |=> $stable(addr_q[i]));
    if (i > 0) begin : g_prev
      assert_prev_addr_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q[i].lock && cfg_q[i].mode == AM_TOR) |=> $stable(addr_q[i-1]));
    end
  end
endmodule

bind pmp_guard pmp_guard_chk #(.N(N_ENT), .AR_W(AR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_q      (cfg_w),
  .addr_q     (addr_w),
  .chk_priv_i (chk_priv_i),
  .match_o    (match_o),
  .win_o      (win_o),
  .allow_o    (allow_o),
  .fault_o    (fault_o)
);

// File: tb/sim_pmp_guard.sv
`timescale 1ns/1ps
module sim_pmp_guard;
  localparam int NE = 8;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          addr_we_i = 1'b0;
  logic [2:0]    addr_idx_i = '0;
  logic [PW-3:0] addr_wd_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [63:0]   cfg_wd_i = '0;
  logic [PW-1:0] chk_pa_i = '0;
  logic [2:0]    chk_acc_i = 3'b001;
  logic [1:0]    chk_priv_i = 2'b11;
  logic [NE-1:0] match_o, win_o;
  logic          allow_o, fault_o;

  int n_chk = 0;
  int n_bad = 0;
  int ar [NE];
  int cf [NE];

  always #2 clk_i = ~clk_i;  // 250 MHz

  pmp_guard #(.N_ENT(NE), .PA_W(PW)) u0 (
    .clk_i, .rst_ni, .addr_we_i, .addr_idx_i, .addr_wd_i, .cfg_we_i, .cfg_wd_i,
    .chk_pa_i, .chk_acc_i, .chk_priv_i, .match_o, .win_o, .allow_o, .fault_o
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s pa=%0d priv=%0d acc=%0d act=%0h exp=%0h", req, chk_pa_i,
               chk_priv_i, chk_acc_i, act, exp);
    end
  endtask

  // coverage model straight from R1..R5
  function automatic bit covers(int i, int pa);
    int md = (cf[i] >> 3) & 3;
    int lo, hi, t, sz, base;
    case (md)
      1: begin  // R2
        lo = (i == 0) ? 0 : ar[i-1] * 4;
        hi = ar[i] * 4;
        return pa >= lo && pa < hi;
      end
      2: return pa >= ar[i] * 4 && pa < ar[i] * 4 + 4;  // R3
      3: begin  // R4
        t = 0;
        while (t < PW - 2 && ((ar[i] >> t) & 1) == 1) t++;
        sz = 8 << t;
        base = ((ar[i] * 4) / sz) * sz;
        return pa >= base && pa < base + sz;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep();
    for (int pa = 0; pa < (1 << PW); pa++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 3; a++) begin
          int em = 0, ew = 0, wi = -1, perm, anyen = 0;
          bit ea;
          chk_pa_i = PW'(pa);
          chk_priv_i = p ? 2'b11 : 2'b00;
          chk_acc_i = 3'(1 << a);
          #1;
          for (int i = 0; i < NE; i++) begin
            if (covers(i, pa)) em |= (1 << i);
            if (((cf[i] >> 3) & 3) != 0) anyen = 1;
          end
          for (int i = NE - 1; i >= 0; i--) if ((em >> i) & 1) wi = i;
          if (wi >= 0) ew = 1 << wi;
          perm = (wi >= 0) ? (cf[wi] & 7) : 0;
          if (p) ea = (wi < 0) || ((cf[wi] & 8'h80) == 0) || (((1 << a) & ~perm) == 0);  // R9
          else   ea = (wi >= 0) ? (((1 << a) & ~perm) == 0) : (anyen == 0);          // R8, R10
          chk(match_o == NE'(em), "R2/R3/R4/R5/R6 match", int'(match_o), em);
          chk(win_o == NE'(ew), "R7 winner", int'(win_o), ew);
          chk(allow_o == ea, "R8/R9/R10 allow", int'(allow_o), int'(ea));
          chk(fault_o == !ea, "R13 fault", int'(fault_o), int'(!ea));
        end
  endtask

  // model applies R11 and R12 to its own copy
  task automatic put_addr(int idx, int val);
    @(negedge clk_i);
    addr_we_i = 1'b1; addr_idx_i = 3'(idx); addr_wd_i = (PW-2)'(val);
    @(negedge clk_i);
    addr_we_i = 1'b0;
    if ((cf[idx] & 8'h80) == 0 &&
        !(idx < NE - 1 && (cf[idx+1] & 8'h80) != 0 && ((cf[idx+1] >> 3) & 3) == 1))
      ar[idx] = val;
  endtask

  task automatic put_cfg(logic [63:0] w);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wd_i = w;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    for (int i = 0; i < NE; i++) if ((cf[i] & 8'h80) == 0) cf[i] = int'(w[8*i +: 8]);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NE; i++) begin ar[i] = 0; cf[i] = 0; end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R14: reset state, nothing enabled so user mode is allowed everywhere
    sweep();

    // overlapping table: TOR, NA4, NAPOT, a disabled entry as TOR base, locked TOR
    put_addr(0, 'h04); put_addr(1, 'h10); put_addr(2, 'h12); put_addr(3, 'h23);
    put_addr(4, 'h30); put_addr(5, 'h3C); put_addr(6, 'h21); put_addr(7, 'h3F);
    put_cfg(64'h89_19_0A_00_1F_14_0B_09);  // R5 byte order, entry 7 locked TOR read-only
    sweep();

    // R11: locked entry 7 keeps its byte and register; R12: register 6 frozen
    put_cfg(64'h0F_19_0A_00_1F_14_0B_0D);
    put_addr(7, 'h10);
    put_addr(6, 'h00);
    put_addr(5, 'h38);  // not protected, takes effect
    sweep();

    // R2 empty TOR range (register 4 above register 5); R4 all-ones block spans space
    put_addr(4, 'h3A);
    put_addr(3, 'h3F);
    sweep();

    // R14: reset releases locks, R11 writes work again
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    clear_model();
    sweep();
    put_addr(6, 'h15);
    put_addr(7, 'h20);
    put_cfg(64'h0D_11_00_00_00_00_00_00);  // R3 NA4 on entry 6, TOR on entry 7
    sweep();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule